// File: doc/BRIEF.md
# Product-Scanning Carry-Less Word Multiplier

This block multiplies two binary polynomials, each stored as N words of BW bits, with schoolbook complexity. Polynomial coefficients are bits, so partial products are carry-less and they are summed with XOR. The block reads one word of each operand per cycle from two caller-owned word memories. Reads are combinational: the block drives a word index and the memory returns that word in the same cycle. Each cycle forms one BW×BW carry-less product.

Products are visited one output column at a time. Column k gathers every operand index pair (i, j) with i + j = k. A double-width running sum collects the whole column before anything is emitted. At the end of a column, its low word is written out. The upper half then slides down to become the carry-in of the next column, and the upper half is zeroed. Each of the 2N result words therefore leaves the block through the write strobe exactly once, in ascending order. A final flush cycle emits the top word. A start pulse launches a run, and done stays high once the last word has gone out.

Top module: `comba_clmul`

## Requirements
- R1: While reset is applied and after it is released with no start, done and wr_en are both low.
- R2: Result word w, as written on wr_data, equals bits [w·BW+BW-1 : w·BW] of the 2N·BW-bit carry-less product of A and B. For both operands, word 0 holds the least significant coefficients.
- R3: In every run, each result index 0 to 2N-1 is presented on wr_idx with wr_en high exactly once, in strictly ascending order.
- R4: done goes high exactly N·N+1 clock cycles after the cycle in which start is accepted, and the last write (index 2N-1) happens in the cycle just before.
- R5: A start pulse received while a run is in progress is ignored. The run completes with the same writes and timing as it would have had without the pulse.
- R6: done stays high with wr_en low until the next start. A start accepted from that state clears done on the next clock edge and begins a new run.
- R7: A run's result depends only on the current operands. The running sum is cleared when a run starts, so a run leaves nothing behind for the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Launch pulse, accepted when the block is idle or done |
| a_idx | output | max(1,clog2(N)) | Word index read from operand A memory |
| a_word | input | BW | Operand A word at a_idx (same cycle) |
| b_idx | output | max(1,clog2(N)) | Word index read from operand B memory |
| b_word | input | BW | Operand B word at b_idx (same cycle) |
| wr_en | output | 1 | Result word strobe |
| wr_idx | output | clog2(2N) | Index of the result word being written |
| wr_data | output | BW | Result word |
| done | output | 1 | High from the cycle after the last write until the next start |

## Verification
Zero operands show that nothing stale leaks into the sum. All-ones operands fill every column to its maximum height and make each column's upper half feed the next one. Single-bit operands placed at the extreme bit positions of the first and last words expose misplaced shifts, a wrong column index, or a top word that is never flushed. Random operands run back to back with no reset in between catch any residue left from the previous run. A start pulse injected in the middle of a run, and a restart from the done state, cover the control corner cases.

// File: rtl/comba_pkg.sv
package comba_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } comba_state_e;
endpackage

// File: rtl/comba_clmul_word.sv
// BW x BW carry-less product: XOR of shifted copies of a selected by bits of b.
module comba_clmul_word #(
  parameter int BW = 8
) (
  input  logic [BW-1:0]   a,
  input  logic [BW-1:0]   b,
  output logic [2*BW-1:0] p
);
  logic [2*BW-1:0] chain [BW+1];

  assign chain[0] = '0;

  generate
    for (genvar k = 0; k < BW; k++) begin : g_row
      logic [2*BW-1:0] row;
      assign row          = b[k] ? ({{BW{1'b0}}, a} << k) : '0;
      assign chain[k + 1] = chain[k] ^ row;
    end
  endgenerate

  assign p = chain[BW];

  always_comb begin
    if (b == BW'(1)) begin
      a_r2_unit_factor: assert (p == {{BW{1'b0}}, a});
    end
    a_r2_top_bit_zero: assert (p[2*BW-1] == 1'b0);
  end
endmodule

// File: rtl/comba_sched.sv
// Column-by-column index generator and run control.
module comba_sched
  import comba_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1,
  parameter int CW = $clog2(2 * N) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output comba_state_e  state_o,
  output logic [IW-1:0] a_idx,
  output logic [IW-1:0] b_idx,
  output logic          commit,
  output logic          flush,
  output logic          clear,
  output logic [CW-1:0] col_o
);
  localparam logic [CW-1:0] NC      = CW'(N);
  localparam logic [CW-1:0] NM1     = CW'(N - 1);
  localparam logic [CW-1:0] LASTCOL = CW'(2 * N - 2);

  comba_state_e  state_q, state_d;
  logic [CW-1:0] col_q, col_d;
  logic [CW-1:0] ai_q, ai_d;
  logic [CW-1:0] lo, hi, col_n, lo_n, bj;
  logic          last, accept;

  always_comb begin
    lo     = (col_q >= NC) ? (col_q - NM1) : '0;
    hi     = (col_q < NC) ? col_q : NM1;
    col_n  = col_q + CW'(1);
    lo_n   = (col_n >= NC) ? (col_n - NM1) : '0;
    bj     = col_q - ai_q;
    last   = (ai_q == hi);
    accept = start && (state_q == ST_IDLE || state_q == ST_DONE);
  end

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    ai_d    = ai_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          state_d = ST_RUN;
          col_d   = '0;
          ai_d    = '0;
        end
      end
      ST_RUN: begin
        if (last) begin
          col_d = col_n;
          ai_d  = lo_n;
          if (col_q == LASTCOL) state_d = ST_FLUSH;
        end else begin
          ai_d = ai_q + CW'(1);
        end
      end
      ST_FLUSH: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      ai_q    <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      ai_q    <= ai_d;
    end
  end

  assign state_o = state_q;
  assign a_idx   = ai_q[IW-1:0];
  assign b_idx   = bj[IW-1:0];
  assign commit  = (state_q == ST_RUN) && last;
  assign flush   = (state_q == ST_FLUSH);
  assign clear   = accept;
  assign col_o   = col_q;

  a_r3_pair_in_column: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (ai_q >= lo && ai_q <= hi && bj < NC));

  a_r3_column_step: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (col_q == $past(col_q) + CW'(1)));

  a_r5_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q == ST_RUN || state_q == ST_FLUSH)) |=> (state_q != ST_IDLE));

  a_r5_no_column_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == ST_RUN && col_q != '0) |=> (col_q != '0));
endmodule

// File: rtl/comba_acc.sv
// Double-width running XOR sum with commit-and-shift and final flush.
module comba_acc #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic          commit,
  input  logic          flush,
  input  logic [2*BW-1:0] prod,
  output logic [BW-1:0] word_o
);
  logic [2*BW-1:0] acc_q, acc_d, sum;
  logic            acc_en;

  always_comb begin
    sum    = acc_q ^ prod;
    acc_en = clear || run || flush;
    acc_d  = acc_q;
    if (clear || flush) begin
      acc_d = '0;
    end else if (run) begin
      acc_d = commit ? {{BW{1'b0}}, sum[2*BW-1:BW]} : sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign word_o = flush ? acc_q[BW-1:0] : sum[BW-1:0];

  a_r2_high_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !clear) |=> (acc_q[2*BW-1:BW] == '0));

  a_r7_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (acc_q == '0));
endmodule

// File: rtl/comba_clmul.sv
module comba_clmul
  import comba_pkg::*;
#(
  parameter int BW = 8,
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int OW = $clog2(2 * N),
  localparam int CW = $clog2(2 * N) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [IW-1:0] a_idx,
  input  logic [BW-1:0] a_word,
  output logic [IW-1:0] b_idx,
  input  logic [BW-1:0] b_word,
  output logic          wr_en,
  output logic [OW-1:0] wr_idx,
  output logic [BW-1:0] wr_data,
  output logic          done
);
  localparam logic [OW-1:0] LASTIDX = OW'(2 * N - 1);

  logic            rst_meta, rst_sync;
  comba_state_e    state;
  logic            commit, flush, clear;
  logic [CW-1:0]   col;
  logic [2*BW-1:0] prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  comba_sched #(.N(N), .IW(IW), .CW(CW)) u_sched (
    .clk     (clk),
    .rst_n   (rst_sync),
    .start   (start),
    .state_o (state),
    .a_idx   (a_idx),
    .b_idx   (b_idx),
    .commit  (commit),
    .flush   (flush),
    .clear   (clear),
    .col_o   (col)
  );

  comba_clmul_word #(.BW(BW)) u_mul (
    .a (a_word),
    .b (b_word),
    .p (prod)
  );

  comba_acc #(.BW(BW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync),
    .clear  (clear),
    .run    (state == ST_RUN),
    .commit (commit),
    .flush  (flush),
    .prod   (prod),
    .word_o (wr_data)
  );

  assign wr_en  = commit || flush;
  assign wr_idx = col[OW-1:0];
  assign done   = (state == ST_DONE);

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(done) |-> ($past(wr_en) && $past(wr_idx) == LASTIDX));

  a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_sync)
    done |-> !wr_en);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync)
    (state == ST_IDLE) |-> (!wr_en && !done));
endmodule

// File: tb/tb_comba_clmul.sv
`timescale 1ns/1ps
module tb_comba_clmul;
  localparam int BW = 8;
  localparam int N  = 4;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int OW = $clog2(2 * N);
  localparam int PW = 2 * N * BW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [IW-1:0] a_idx, b_idx;
  logic [BW-1:0] a_word, b_word;
  logic          wr_en;
  logic [OW-1:0] wr_idx;
  logic [BW-1:0] wr_data;
  logic          done;

  logic [N*BW-1:0] a_v, b_v;
  logic [BW-1:0]   got [2*N];
  int              wr_count;
  int              next_idx;
  int              order_bad;
  int              errors = 0;
  int              checks = 0;
  int              cycles = 0;

  always #2.5 clk = ~clk;

  assign a_word = a_v[a_idx*BW +: BW];
  assign b_word = b_v[b_idx*BW +: BW];

  comba_clmul #(.BW(BW), .N(N)) dut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .a_idx (a_idx), .a_word (a_word), .b_idx (b_idx), .b_word (b_word),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data), .done (done)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (int'(wr_idx) != next_idx) order_bad++;
      got[wr_idx] = wr_data;
      wr_count++;
      next_idx++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [N*BW-1:0] a, input logic [N*BW-1:0] b);
    logic [PW-1:0] r = '0;
    for (int i = 0; i < N*BW; i++)
      for (int j = 0; j < N*BW; j++)
        r[i+j] ^= a[i] & b[j];
    return r;
  endfunction

  // R2 R3 R4 R5: one run; inject_at>0 pulses start that many cycles into the run
  task automatic run_mul(input logic [N*BW-1:0] a, input logic [N*BW-1:0] b, input int inject_at, input string name);
    logic [PW-1:0] exp_p;
    int cnt;
    a_v = a; b_v = b;
    exp_p = ref_mul(a, b);
    wr_count = 0; next_idx = 0; order_bad = 0;
    for (int w = 0; w < 2*N; w++) got[w] = 'x;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check(!done, {"R6 done cleared after start ", name}, 64'(done), 64'd0);
    cnt = 0;
    while (cnt < 4*N*N + 10) begin
      if (inject_at > 0 && cnt == inject_at) start = 1'b1;
      @(posedge clk); cnt++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
    check(cnt == N*N + 1, {"R4 done latency ", name}, 64'(cnt), 64'(N*N + 1));
    check(wr_count == 2*N && order_bad == 0, {"R3 write count/order ", name},
          64'(wr_count), 64'(2*N));
    for (int w = 0; w < 2*N; w++)
      check(got[w] === exp_p[w*BW +: BW], {"R2 word ", name}, 64'(got[w]), 64'(exp_p[w*BW +: BW]));
  endtask

  function automatic logic [N*BW-1:0] rnd_op();
    logic [N*BW-1:0] v;
    for (int w = 0; w < N; w++) v[w*BW +: BW] = BW'($urandom);
    return v;
  endfunction

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; a_v = '0; b_v = '0;
    wr_count = 0; next_idx = 0; order_bad = 0;
    repeat (3) @(negedge clk);
    check(!done && !wr_en, "R1 in reset", {62'd0, done, wr_en}, 64'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!done && !wr_en && wr_count == 0, "R1 after release", {62'd0, done, wr_en}, 64'd0);
  endtask

  task automatic test_done_hold();
    repeat (5) @(negedge clk);
    check(done && wr_count == 2*N, "R6 done held, no writes", {63'd0, done}, 64'd1);
  endtask

  initial begin
    test_reset();
    run_mul('0, '0, 0, "zero");
    run_mul('1, '1, 0, "all-ones");
    run_mul({{(N*BW-1){1'b0}}, 1'b1}, {1'b1, {(N*BW-1){1'b0}}}, 0, "lsb*msb");
    run_mul({1'b1, {(N*BW-1){1'b0}}}, {1'b1, {(N*BW-1){1'b0}}}, 0, "msb*msb");
    run_mul((N*BW)'(1) << (BW-1), (N*BW)'(1) << BW, 0, "word-edge bits");
    test_done_hold();
    for (int t = 0; t < 6; t++) run_mul(rnd_op(), rnd_op(), 0, "R7 random back-to-back");
    run_mul(rnd_op(), rnd_op(), N*N/2, "R5 start mid-run");
    run_mul(rnd_op(), rnd_op(), N*N, "R5 start in flush");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule